// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block takes a stereo pair of 32-bit PCM samples and puts them on one serial data line, framed by a bit clock and a left/right word clock that arrive from outside. The transmitter is a slave. It never generates either clock. It watches both clocks through a two-stage synchroniser running on a fast system clock. On every drive edge of the bit clock it works out which channel and which bit position the line is in, then drives the next data bit.

One shifter covers five framings: left-justified, right-justified, I2S, DSP with early sync and DSP with late sync. It supports four word lengths. One configuration bit inverts the bit clock. A second bit inverts the word clock, or in DSP framing chooses early or late timing. Samples are written into a holding register at any time with a one-cycle strobe. The held pair is taken over at the start of each frame. If no new pair has arrived, the last pair is sent again.

Top module: `pcm_serial_tx`

## Requirements
- R1: Each word is sent MSB first, and the sample is MSB-aligned: bit 31 of the input goes out first. The word-length code gives 00 = 16, 01 = 20, 10 = 24 and 11 = 32 bits.
- R2: With format code 01 (left-justified), the left MSB is driven on the same drive edge at which the word clock goes high. The right MSB is driven on the drive edge at which it goes low.
- R3: With format code 10 (I2S), the MSB is driven one bit clock after the word-clock change. A low word clock means left and a high word clock means right.
- R4: With format code 00 (right-justified), the LSB is driven on the last drive edge before the word-clock change. The word clock is high for left. Leading bit positions are low, and code 11 sends 24 bits.
- R5: With format code 11 (DSP), a rising word clock marks the frame. The alternate bit set to 0 means early timing: the left MSB is driven one bit clock after the rise. Set to 1, it means late timing: the left MSB is driven on the rising edge itself. The right word follows the left word with no gap, and the line stays low after the right word.
- R6: In the non-DSP formats, setting the alternate bit swaps the word-clock level that marks the left channel.
- R7: With the bit-clock invert bit at 0, data changes after falling bit-clock edges. With it at 1, data changes after rising edges.
- R8: In the left-justified and I2S formats, bit positions after the word inside a half-frame are driven low.
- R9: A pair written while a frame is running is first sent in the next frame. A frame with no new write repeats the previous pair.
- R10: While reset is asserted, the serial output is low.
- R11: The serial output changes only on the third system-clock rising edge after a bit-clock drive edge reaches the input. It holds its value between such updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock from the frame master |
| wordClk | input | 1 | Left/right word clock or frame sync |
| cfgFormat | input | 2 | Framing: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP |
| cfgWordLen | input | 2 | Word length code: 00 16, 01 20, 10 24, 11 32 bits |
| cfgLrAlt | input | 1 | Word-clock inversion (non-DSP) or late sync select (DSP) |
| cfgBitClkInv | input | 1 | Swaps the drive and sample edges of the bit clock |
| pairLeft | input | 32 | Left sample, MSB-aligned |
| pairRight | input | 32 | Right sample, MSB-aligned |
| pairValid | input | 1 | One-cycle write strobe for the sample pair |
| serData | output | 1 | Serial audio data |

## Verification
The bench drives each bit-clock level for four system clocks. A data bit therefore becomes valid three system clocks after its drive edge: two synchroniser stages plus the output register. The bench reads the line on the fourth falling system-clock edge, just before the opposite bit-clock edge. At one chosen edge it also reads the line after two and after three system clocks, to pin down that latency exactly. A new sample pair takes effect only at the next frame start. So every configuration gets one warm-up frame, and the frames after it are compared bit for bit against the framing rules.

// File: rtl/pcm_serial_tx_pkg.sv
package pcm_serial_tx_pkg;

  parameter int unsigned POS_W = 8;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  // Strobes from the edge/position control to the datapath
  typedef struct packed {
    logic             drive;
    logic             frameStart;
    logic             isLeft;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] halfLen;
  } strobe_t;

  function automatic logic [POS_W-1:0] wordBits(input logic [1:0] code, input fmt_e f);
    case (code)
      2'b00:   wordBits = POS_W'(16);
      2'b01:   wordBits = POS_W'(20);
      2'b10:   wordBits = POS_W'(24);
      default: wordBits = (f == FMT_RJ) ? POS_W'(24) : POS_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/pcm_serial_tx_ctrl.sv
module pcm_serial_tx_ctrl
  import pcm_serial_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitClk,
  input  logic    wordClk,
  input  fmt_e    fmt,
  input  logic    lrAlt,
  input  logic    bitClkInv,
  output strobe_t strb
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] bcSync, lrSync;
  logic bcNorm, bcPrev, driveEv;
  logic lr0, lr1, lr2;
  logic useDelayed, lrCur, lrPrv, curEff, prvEff;
  logic halfStart, frameStart, isLeft, isDsp;
  logic [POS_W-1:0] posReg, posNow, halfLenReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bcSync <= '0;
      lrSync <= '0;
      bcPrev <= 1'b0;
    end else begin
      bcSync <= {bcSync[SYNC_N-2:0], bitClk};
      lrSync <= {lrSync[SYNC_N-2:0], wordClk};
      bcPrev <= bcNorm;
    end
  end

  assign bcNorm  = bcSync[SYNC_N-1] ^ bitClkInv;
  assign driveEv = bcPrev & ~bcNorm;
  assign lr0     = lrSync[SYNC_N-1];
  assign isDsp   = (fmt == FMT_DSP);

  // I2S and early sync read the word clock one bit clock late
  assign useDelayed = (fmt == FMT_I2S) || (isDsp && !lrAlt);
  assign lrCur      = useDelayed ? lr1 : lr0;
  assign lrPrv      = useDelayed ? lr2 : lr1;
  assign curEff     = lrCur ^ (lrAlt & ~isDsp);
  assign prvEff     = lrPrv ^ (lrAlt & ~isDsp);

  always_comb begin
    if (isDsp) begin
      halfStart  = lrCur & ~lrPrv;
      frameStart = halfStart;
      isLeft     = 1'b1;
    end else begin
      halfStart  = curEff ^ prvEff;
      isLeft     = curEff ^ (fmt == FMT_I2S);
      frameStart = halfStart & isLeft;
    end
    if (halfStart)             posNow = '0;
    else if (posReg == POS_MAX) posNow = POS_MAX;
    else                       posNow = posReg + POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lr1        <= 1'b0;
      lr2        <= 1'b0;
      posReg     <= POS_MAX;
      halfLenReg <= '0;
    end else if (driveEv) begin
      lr1    <= lr0;
      lr2    <= lr1;
      posReg <= posNow;
      if (halfStart && !isDsp)
        halfLenReg <= (posReg == POS_MAX) ? POS_MAX : posReg + POS_W'(1);
    end
  end

  assign strb.drive      = driveEv;
  assign strb.frameStart = frameStart;
  assign strb.isLeft     = isLeft;
  assign strb.pos        = posNow;
  assign strb.halfLen    = halfLenReg;

endmodule

// File: rtl/pcm_serial_tx_dp.sv
module pcm_serial_tx_dp
  import pcm_serial_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  fmt_e                fmt,
  input  logic [1:0]          wordLen,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  input  logic                inValid,
  output logic                sdOut
);

  localparam int unsigned IDX_W = $clog2(SAMPLE_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] pendL, pendR, actL, actR, curL, curR, curWord;
  logic [POS_W-1:0]    wlEff, q, k;
  logic                haveBit, bitNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendL <= '0;
      pendR <= '0;
      actL  <= '0;
      actR  <= '0;
    end else begin
      if (inValid) begin
        pendL <= inLeft;
        pendR <= inRight;
      end
      if (strb.drive && strb.frameStart) begin
        actL <= pendL;
        actR <= pendR;
      end
    end
  end

  assign wlEff = wordBits(wordLen, fmt);
  assign curL  = strb.frameStart ? pendL : actL;
  assign curR  = strb.frameStart ? pendR : actR;

  always_comb begin
    haveBit = 1'b0;
    q       = '0;
    k       = '0;
    curWord = strb.isLeft ? curL : curR;
    case (fmt)
      FMT_DSP: begin
        if (strb.pos < wlEff) begin
          haveBit = 1'b1;
          q       = strb.pos;
          curWord = curL;
        end else if ({1'b0, strb.pos} < {wlEff, 1'b0}) begin
          haveBit = 1'b1;
          q       = strb.pos - wlEff;
          curWord = curR;
        end
      end
      FMT_RJ: begin
        if (strb.halfLen != '0 && strb.pos < strb.halfLen) begin
          k = strb.halfLen - POS_W'(1) - strb.pos;
          if (k < wlEff) begin
            haveBit = 1'b1;
            q       = wlEff - POS_W'(1) - k;
          end
        end
      end
      default: begin
        if (strb.pos < wlEff) begin
          haveBit = 1'b1;
          q       = strb.pos;
        end
      end
    endcase
    bitNext = haveBit & curWord[TOP_IDX - IDX_W'(q)];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           sdOut <= 1'b0;
    else if (strb.drive) sdOut <= bitNext;
  end

  AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    !strb.drive |=> $stable(sdOut)); // R11

  AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drive && (fmt == FMT_LJ || fmt == FMT_I2S) && strb.pos >= wlEff) |=> !sdOut); // R8

  AST_DSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drive && fmt == FMT_DSP && {1'b0, strb.pos} >= {wlEff, 1'b0}) |=> !sdOut); // R5

  AST_RJ_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drive && fmt == FMT_RJ &&
     (strb.halfLen == '0 || ({1'b0, strb.pos} + {1'b0, wlEff} < {1'b0, strb.halfLen}))) |=> !sdOut); // R4

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_serial_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                wordClk,
  input  logic [1:0]          cfgFormat,
  input  logic [1:0]          cfgWordLen,
  input  logic                cfgLrAlt,
  input  logic                cfgBitClkInv,
  input  logic [SAMPLE_W-1:0] pairLeft,
  input  logic [SAMPLE_W-1:0] pairRight,
  input  logic                pairValid,
  output logic                serData
);

  fmt_e    fmt;
  strobe_t strb;

  assign fmt = fmt_e'(cfgFormat);

  pcm_serial_tx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitClk    (bitClk),
    .wordClk   (wordClk),
    .fmt       (fmt),
    .lrAlt     (cfgLrAlt),
    .bitClkInv (cfgBitClkInv),
    .strb      (strb)
  );

  pcm_serial_tx_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .fmt     (fmt),
    .wordLen (cfgWordLen),
    .inLeft  (pairLeft),
    .inRight (pairRight),
    .inValid (pairValid),
    .sdOut   (serData)
  );

endmodule

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, bitClk, wordClk, cfgLrAlt, cfgBitClkInv, pairValid, serData;
  logic [1:0]  cfgFormat, cfgWordLen;
  logic [31:0] pairLeft, pairRight;

  int checks = 0;
  int fails  = 0;

  pcm_serial_tx u0 (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk),
    .cfgFormat(cfgFormat), .cfgWordLen(cfgWordLen), .cfgLrAlt(cfgLrAlt),
    .cfgBitClkInv(cfgBitClkInv), .pairLeft(pairLeft), .pairRight(pairRight),
    .pairValid(pairValid), .serData(serData)
  );

  typedef struct packed {
    logic [1:0]  fmt;
    logic [1:0]  wl;
    logic        lrp;
    logic        bcp;
    logic [31:0] left;
    logic [31:0] right;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 2'b10, 1'b0, 1'b0, 32'hA5C3_F00F, 32'h1234_5678, 4'd2},
    '{2'b01, 2'b00, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hC3C3_C3C3, 4'd8},
    '{2'b01, 2'b11, 1'b1, 1'b0, 32'h8000_0001, 32'h7E5A_3C01, 4'd6},
    '{2'b10, 2'b10, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h0F0F_1234, 4'd3},
    '{2'b10, 2'b01, 1'b1, 1'b1, 32'h9ABC_DEF0, 32'h1357_9BDF, 4'd7},
    '{2'b00, 2'b10, 1'b0, 1'b0, 32'hF0E1_D2C3, 32'h89AB_CDEF, 4'd4},
    '{2'b00, 2'b11, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 4'd4},
    '{2'b00, 2'b00, 1'b0, 1'b0, 32'hB00B_FFFF, 32'h4321_FFFF, 4'd1},
    '{2'b11, 2'b00, 1'b0, 1'b0, 32'hCAFE_0000, 32'hBABE_0000, 4'd5},
    '{2'b11, 2'b11, 1'b1, 1'b0, 32'h0123_4567, 32'h89AB_CDEF, 4'd5},
    '{2'b11, 2'b01, 1'b0, 1'b1, 32'h5A5A_5FFF, 32'hE1E1_EFFF, 4'd7},
    '{2'b01, 2'b01, 1'b0, 1'b0, 32'hFEDC_BFFF, 32'h0246_8FFF, 4'd1}
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: reqName = "R1";
      4'd2: reqName = "R2";
      4'd3: reqName = "R3";
      4'd4: reqName = "R4";
      4'd5: reqName = "R5";
      4'd6: reqName = "R6";
      4'd7: reqName = "R7";
      default: reqName = "R8";
    endcase
  endfunction

  function automatic int bitsFor(input logic [1:0] f, input logic [1:0] c);
    case (c)
      2'b00: bitsFor = 16;
      2'b01: bitsFor = 20;
      2'b10: bitsFor = 24;
      default: bitsFor = (f == 2'b00) ? 24 : 32;
    endcase
  endfunction

  // Expected 64-bit frame (index = bit clock number in the frame), 32 bits per half
  function automatic logic [63:0] expFrame(input logic [1:0] f, input logic [1:0] c,
                                           input logic lrp, input logic [31:0] l,
                                           input logic [31:0] r);
    int wl = bitsFor(f, c);
    logic [63:0] e = '0;
    for (int b = 0; b < 64; b++) begin
      int q = -1;
      int k;
      int p;
      logic rightCh = 1'b0;
      case (f)
        2'b01: begin rightCh = (b >= 32); q = b % 32; end
        2'b10: begin p = (b + 63) % 64; rightCh = (p >= 32); q = p % 32; end
        2'b00: begin rightCh = (b >= 32); k = 31 - (b % 32); if (k < wl) q = wl - 1 - k; end
        default: begin
          p = lrp ? b : (b + 63) % 64;
          if (p < wl) q = p;
          else if (p < 2 * wl) begin q = p - wl; rightCh = 1'b1; end
        end
      endcase
      if (q >= 0 && q < wl) e[b] = rightCh ? r[31 - q] : l[31 - q];
    end
    return e;
  endfunction

  task automatic check1(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic checkFrame(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s frame actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic writePair(input logic [31:0] l, input logic [31:0] r);
    pairLeft  = l;
    pairRight = r;
    pairValid = 1'b1;
    @(negedge clk);
    pairValid = 1'b0;
  endtask

  function automatic logic lrFor(input int b);
    logic leftLvl;
    if (cfgFormat == 2'b11) return (b == 0);
    leftLvl = (cfgFormat == 2'b10 ? 1'b0 : 1'b1) ^ cfgLrAlt;
    return (b < 32) ? leftLvl : ~leftLvl;
  endfunction

  // One frame of 64 bit clocks, four system clocks per bit-clock level
  task automatic runFrame(output logic [63:0] cap, output logic lat2, output logic lat3,
                          input int writeAt, input logic [31:0] nL, input logic [31:0] nR);
    lat2 = 1'b0;
    lat3 = 1'b0;
    for (int b = 0; b < 64; b++) begin
      bitClk  = cfgBitClkInv;
      wordClk = lrFor(b);
      if (b == writeAt) begin
        writePair(nL, nR);
        repeat (3) @(negedge clk);
      end else begin
        repeat (2) @(negedge clk);
        if (b == 0) lat2 = serData;
        @(negedge clk);
        if (b == 0) lat3 = serData;
        @(negedge clk);
      end
      cap[b] = serData;
      bitClk = ~cfgBitClkInv;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] cap;
    logic l2, l3;
    rstN = 1'b0; bitClk = 1'b1; wordClk = 1'b0; pairValid = 1'b0;
    cfgFormat = 2'b01; cfgWordLen = 2'b10; cfgLrAlt = 1'b0; cfgBitClkInv = 1'b0;
    pairLeft = '0; pairRight = '0;
    repeat (5) @(negedge clk);
    check1("R10", serData, 1'b0, "output during reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      cfgFormat    = VECS[v].fmt;
      cfgWordLen   = VECS[v].wl;
      cfgLrAlt     = VECS[v].lrp;
      cfgBitClkInv = VECS[v].bcp;
      bitClk       = ~VECS[v].bcp;
      wordClk      = (VECS[v].fmt == 2'b11) ? 1'b0 : ~lrFor(0);
      writePair(VECS[v].left, VECS[v].right);
      repeat (8) @(negedge clk);
      runFrame(cap, l2, l3, -1, '0, '0);
      for (int f = 0; f < 2; f++) begin
        runFrame(cap, l2, l3, -1, '0, '0);
        checkFrame(reqName(VECS[v].req), cap,
                   expFrame(VECS[v].fmt, VECS[v].wl, VECS[v].lrp, VECS[v].left, VECS[v].right));
      end
    end

    // Directed: latency (R11) and frame-boundary sample loading (R9), left-justified 16-bit
    cfgFormat = 2'b01; cfgWordLen = 2'b00; cfgLrAlt = 1'b0; cfgBitClkInv = 1'b0;
    bitClk = 1'b1; wordClk = 1'b0;
    writePair(32'hFFFF_0000, 32'h0000_0000);
    repeat (8) @(negedge clk);
    runFrame(cap, l2, l3, -1, '0, '0);
    runFrame(cap, l2, l3, 40, 32'h1234_0000, 32'hABCD_0000);
    check1("R11", l2, 1'b0, "two clocks after drive edge");
    check1("R11", l3, 1'b1, "three clocks after drive edge");
    checkFrame("R9", cap, expFrame(2'b01, 2'b00, 1'b0, 32'hFFFF_0000, 32'h0000_0000));
    runFrame(cap, l2, l3, -1, '0, '0);
    checkFrame("R9", cap, expFrame(2'b01, 2'b00, 1'b0, 32'h1234_0000, 32'hABCD_0000));
    runFrame(cap, l2, l3, -1, '0, '0);
    checkFrame("R9", cap, expFrame(2'b01, 2'b00, 1'b0, 32'h1234_0000, 32'hABCD_0000));

    // Reset clears the line mid-stream (R10)
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check1("R10", serData, 1'b0, "output after reset mid-frame");
    rstN = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule